// File: doc/BRIEF.md
# Entropy Health Test Gate

This block sits between a raw noise source and the word-level consumers of a true random number generator. It takes a serial stream of raw bits, one per cycle at most, and runs two continuous health tests on them. The repetition count test watches for a run of identical bits that is too long. The adaptive proportion test splits the stream into disjoint 1024-bit windows and counts how often the first bit of each window appears in that window.

The bits of a window are packed into 32-bit words and held in an internal 1024-bit buffer. No word leaves the block until the whole window that contains it has passed both tests. When a window passes, its 32 words come out on 32 consecutive cycles while the next window is already being collected into the same storage.

Any test failure sets a sticky error flag and drops the held data. The block then ignores raw bits and produces no words until it is restarted, either by the asynchronous reset or by the synchronous restart input. The interrupt output is a level copy of the error flag, gated by an enable. A cutoff input of zero selects the built-in default, so the block works with no configuration.

Top module: `entropy_health_gate`

## Requirements
- R1: After reset `word_valid`, `health_err` and `irq` are all 0.
- R2: Raw bit k of a window (k counting accepted bits from 0) becomes bit k mod 32 of word k/32. The 32 words of a passing window appear in index order on 32 consecutive cycles. The first appears one cycle after the clock edge that accepts the window's last bit. No word of a window appears before that edge.
- R3: The repetition test fails when an accepted bit makes the current run of equal bits reach `rct_cut`. A run one shorter than the cutoff does not fail.
- R4: The proportion test fails when the count of bits in the current window that equal the window's first bit reaches `apt_cut`. A window whose count ends one below the cutoff passes.
- R5: A cutoff input of 0 selects the defaults: 32 for the repetition test and 589 for the proportion test.
- R6: On a failure, `health_err` is 1 from the accepting edge onward, stays 1 until restart, and all later raw bits are ignored. `word_valid` stays 0 from then on, and no word of the failing window is ever released.
- R7: `irq` equals `health_err` while `irq_en` is 1, and is 0 while `irq_en` is 0.
- R8: `clr` held for one cycle clears the error, the health test state and the window position, so the next accepted bit starts a fresh window.
- R9: Two windows fed back to back at one bit per cycle both release all their words intact, although they share one 1024-bit buffer.
- R10: Cycles with `raw_valid` low are skipped by both tests and by the packing. They do not break a run or shift any bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous full restart |
| raw_bit | input | 1 | Raw entropy bit |
| raw_valid | input | 1 | Qualifies `raw_bit` for this cycle |
| rct_cut | input | 8 | Repetition run cutoff, 0 selects 32 |
| apt_cut | input | 11 | Proportion count cutoff, 0 selects 589 |
| irq_en | input | 1 | Interrupt enable |
| word_out | output | 32 | Released random word |
| word_valid | output | 1 | `word_out` holds a released word this cycle |
| health_err | output | 1 | Sticky health test failure flag |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that `clr` and `rst_n` are the only ways out of the error state. They also assume that the raw stream never fills two windows within the 33 cycles a release needs, which holds because at most one bit is accepted per cycle. The stimulus drives every input at the falling edge and feeds at most one bit per cycle. It uses patterns whose runs and first-bit counts are known in advance: exactly 512 of each value per window and runs under 31. This lets the bench predict every pass, every failure and the exact cutoff boundaries without reference to the design.

// File: rtl/ehg_pkg.sv
`timescale 1ns/1ps
package ehg_pkg;
  // A cutoff of zero means "use the built-in default".
  function automatic logic [15:0] pick_cut(input logic [15:0] prog, input logic [15:0] dflt);
    return (prog == 16'd0) ? dflt : prog;
  endfunction

  // A test fails once its counter has reached the cutoff.
  function automatic logic reached(input logic [15:0] cnt, input logic [15:0] cut);
    return cnt >= cut;
  endfunction
endpackage

// File: rtl/ehg_rep_test.sv
`timescale 1ns/1ps
module ehg_rep_test import ehg_pkg::*; #(
  parameter int RUN_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        bit_in,
  input  logic        bit_ok,
  input  logic [15:0] cut,
  output logic        fail
);
  logic             have_prev;
  logic             prev_bit;
  logic [RUN_W-1:0] run_len;
  logic [RUN_W-1:0] run_nxt;

  always_comb begin
    if (!have_prev || (bit_in != prev_bit)) run_nxt = RUN_W'(1);
    else if (&run_len)                      run_nxt = run_len;
    else                                    run_nxt = run_len + 1'b1;
    fail = bit_ok && reached(16'(run_nxt), cut);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_bit  <= 1'b0;
      run_len   <= '0;
    end else if (clr) begin
      have_prev <= 1'b0;
      prev_bit  <= 1'b0;
      run_len   <= '0;
    end else if (bit_ok) begin
      have_prev <= 1'b1;
      prev_bit  <= bit_in;
      run_len   <= run_nxt;
    end
  end
endmodule

// File: rtl/ehg_prop_test.sv
`timescale 1ns/1ps
module ehg_prop_test import ehg_pkg::*; #(
  parameter int WIN_BITS = 1024,
  parameter int POS_W    = $clog2(WIN_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_in,
  input  logic             bit_ok,
  input  logic [15:0]      cut,
  output logic             fail,
  output logic             win_end,
  output logic [POS_W-1:0] pos
);
  localparam int CNT_W = $clog2(WIN_BITS + 1);

  logic             ref_bit;
  logic [CNT_W-1:0] match;
  logic [CNT_W-1:0] match_nxt;
  logic             first;

  always_comb begin
    first     = (pos == '0);
    match_nxt = first ? CNT_W'(1) : match + CNT_W'(bit_in == ref_bit);
    fail      = bit_ok && reached(16'(match_nxt), cut);
    win_end   = bit_ok && (pos == POS_W'(WIN_BITS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      ref_bit <= 1'b0;
      match   <= '0;
    end else if (clr) begin
      pos     <= '0;
      ref_bit <= 1'b0;
      match   <= '0;
    end else if (bit_ok) begin
      pos   <= win_end ? '0 : pos + 1'b1;
      match <= match_nxt;
      if (first) ref_bit <= bit_in;
    end
  end
endmodule

// File: rtl/ehg_hold_buf.sv
`timescale 1ns/1ps
module ehg_hold_buf #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 32,
  parameter int POS_W  = 10,
  parameter int IDX_W  = $clog2(WORDS),
  parameter int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              bit_ok,
  input  logic              bit_in,
  input  logic [POS_W-1:0]  pos,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] word_nxt;
  logic              word_done;

  // Earliest bit ends up in bit 0 once the word is complete.
  assign word_nxt  = {bit_in, sh[WORD_W-1:1]};
  assign word_done = bit_ok && (pos[BIT_W-1:0] == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (bit_ok) sh <= word_nxt;
    if (word_done) mem[pos[POS_W-1:BIT_W]] <= word_nxt;
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/entropy_health_gate.sv
`timescale 1ns/1ps
module entropy_health_gate import ehg_pkg::*; #(
  parameter int WORD_W   = 32,
  parameter int WIN_BITS = 1024,
  parameter int RCT_W    = 8,
  parameter int APT_W    = 11,
  parameter int RCT_DEF  = 32,
  parameter int APT_DEF  = 589
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              raw_bit,
  input  logic              raw_valid,
  input  logic [RCT_W-1:0]  rct_cut,
  input  logic [APT_W-1:0]  apt_cut,
  input  logic              irq_en,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              health_err,
  output logic              irq
);
  localparam int WORDS = WIN_BITS / WORD_W;
  localparam int IDX_W = $clog2(WORDS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int POS_W = $clog2(WIN_BITS);

  logic              bit_ok;
  logic [15:0]       rct_lim;
  logic [15:0]       apt_lim;
  logic              rct_fail;
  logic              apt_fail;
  logic              any_fail;
  logic              win_end;
  logic              win_pass;
  logic [POS_W-1:0]  pos;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic              drain_act;

  assign bit_ok   = raw_valid && !health_err && !clr;
  assign rct_lim  = pick_cut(16'(rct_cut), 16'(RCT_DEF));
  assign apt_lim  = pick_cut(16'(apt_cut), 16'(APT_DEF));
  assign any_fail = rct_fail || apt_fail;
  assign win_pass = win_end && !any_fail;
  assign irq      = health_err && irq_en;

  ehg_rep_test #(.RUN_W(RCT_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(raw_bit), .bit_ok(bit_ok),
    .cut(rct_lim), .fail(rct_fail)
  );

  ehg_prop_test #(.WIN_BITS(WIN_BITS), .POS_W(POS_W)) u_prop (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(raw_bit), .bit_ok(bit_ok),
    .cut(apt_lim), .fail(apt_fail), .win_end(win_end), .pos(pos)
  );

  ehg_hold_buf #(.WORD_W(WORD_W), .WORDS(WORDS), .POS_W(POS_W), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_buf (
    .clk(clk), .bit_ok(bit_ok), .bit_in(raw_bit), .pos(pos),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      health_err <= 1'b0;
      drain_act  <= 1'b0;
      rd_idx     <= '0;
      word_valid <= 1'b0;
      word_out   <= '0;
    end else if (clr) begin
      health_err <= 1'b0;
      drain_act  <= 1'b0;
      rd_idx     <= '0;
      word_valid <= 1'b0;
      word_out   <= '0;
    end else if (any_fail) begin
      health_err <= 1'b1;
      drain_act  <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= drain_act;
      if (drain_act) begin
        word_out <= rd_word;
        rd_idx   <= rd_idx + 1'b1;
        if (rd_idx == IDX_W'(WORDS - 1)) drain_act <= 1'b0;
      end
      if (win_pass) begin
        drain_act <= 1'b1;
        rd_idx    <= '0;
      end
    end
  end
endmodule

// File: rtl/ehg_chk.sv
`timescale 1ns/1ps
module ehg_chk #(
  parameter int WORDS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic irq_en,
  input logic word_valid,
  input logic health_err,
  input logic irq,
  input logic rct_fail,
  input logic apt_fail,
  input logic win_pass
);
  logic [15:0] vrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vrun <= '0;
    else if (word_valid) vrun <= vrun + 1'b1;
    else                 vrun <= '0;
  end

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(win_pass, 2));

  p_rct_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rct_fail && !clr |=> health_err);

  p_apt_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apt_fail && !clr |=> health_err);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    health_err && !clr |=> health_err);

  p_valid_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !health_err);

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    health_err && irq_en |-> irq);

  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !health_err && !word_valid);

  p_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> vrun < 16'(WORDS));
endmodule

bind entropy_health_gate ehg_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .irq_en(irq_en),
  .word_valid(word_valid), .health_err(health_err), .irq(irq),
  .rct_fail(rct_fail), .apt_fail(apt_fail), .win_pass(win_pass)
);

// File: tb/sim_entropy_health_gate.sv
`timescale 1ns/1ps
module sim_entropy_health_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        raw_bit = 1'b0;
  logic        raw_valid = 1'b0;
  logic [7:0]  rct_cut = 8'd0;
  logic [10:0] apt_cut = 11'd0;
  logic        irq_en = 1'b1;
  logic [31:0] word_out;
  logic        word_valid;
  logic        health_err;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int ngot    = 0;
  logic [31:0] got [256];
  int          got_cyc [256];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  entropy_health_gate u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .raw_bit(raw_bit), .raw_valid(raw_valid),
    .rct_cut(rct_cut), .apt_cut(apt_cut), .irq_en(irq_en),
    .word_out(word_out), .word_valid(word_valid), .health_err(health_err), .irq(irq)
  );

  always @(negedge clk) begin
    if (word_valid && ngot < 256) begin
      got[ngot]     = word_out;
      got_cyc[ngot] = cyc;
      ngot          = ngot + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Each window holds exactly 512 ones and runs shorter than 31.
  function automatic logic [31:0] pat(input int win, input int w);
    logic [15:0] x;
    x = 16'h5A5A ^ {win[3:0], 7'b0, w[4:0]};
    return {~x, x};
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    raw_bit   = b;
    raw_valid = 1'b1;
  endtask

  task automatic skip_bit(input logic b);
    @(negedge clk);
    raw_bit   = b;
    raw_valid = 1'b0;
  endtask

  task automatic quiet();
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    raw_valid = 1'b0;
    rst_n     = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    ngot = 0;
  endtask

  // pre >= 0: words already released before the last bit of this window.
  task automatic send_window(input int win, input bit gaps, input int pre);
    for (int w = 0; w < 32; w++) begin
      logic [31:0] d;
      d = pat(win, w);
      for (int j = 0; j < 32; j++) begin
        if (w == 31 && j == 31 && pre >= 0)
          chk(ngot == pre, "R2 no word before window end", ngot, pre);
        send_bit(d[j]);
        if (gaps && (j % 3 == 0)) skip_bit(~d[j]);
      end
    end
  endtask

  task automatic expect_window(input int base, input int win, input string tag);
    for (int k = 0; k < 32; k++) begin
      chk(got[base + k] == pat(win, k), tag, got[base + k], pat(win, k));
      chk(got_cyc[base + k] == got_cyc[base] + k, {tag, " consecutive"},
          got_cyc[base + k], got_cyc[base] + k);
    end
  endtask

  task automatic t_reset();
    reset_dut();
    chk(word_valid == 1'b0, "R1 valid after reset", word_valid, 0);
    chk(health_err == 1'b0, "R1 err after reset", health_err, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
  endtask

  task automatic t_default_window();
    reset_dut();
    rct_cut = 0; apt_cut = 0;
    send_window(0, 0, 0);
    quiet();
    wait_cyc(40);
    chk(ngot == 32, "R2 R5 word count", ngot, 32);
    expect_window(0, 0, "R2 word data");
    chk(health_err == 1'b0, "R5 default cutoffs pass", health_err, 0);
  endtask

  task automatic t_gaps();
    reset_dut();
    send_window(7, 1, 0);
    quiet();
    wait_cyc(40);
    chk(ngot == 32, "R10 word count with gaps", ngot, 32);
    expect_window(0, 7, "R10 word data with gaps");
  endtask

  task automatic t_back2back();
    reset_dut();
    send_window(1, 0, 0);
    send_window(2, 0, 32);
    quiet();
    wait_cyc(40);
    chk(ngot == 64, "R9 two windows count", ngot, 64);
    expect_window(0, 1, "R9 first window");
    expect_window(32, 2, "R9 second window");
  endtask

  task automatic t_apt_edge();
    reset_dut();
    apt_cut = 11'd513;
    send_window(3, 0, 0);
    quiet();
    wait_cyc(40);
    chk(health_err == 1'b0, "R4 count one below cutoff passes", health_err, 0);
    chk(ngot == 32, "R4 passing window released", ngot, 32);
    expect_window(0, 3, "R4 window data");
    reset_dut();
    apt_cut = 11'd512;
    send_window(4, 0, 0);
    quiet();
    wait_cyc(40);
    chk(health_err == 1'b1, "R4 count at cutoff fails", health_err, 1);
    chk(ngot == 0, "R6 failing window not released", ngot, 0);
    apt_cut = 11'd0;
  endtask

  task automatic t_apt_default();
    reset_dut();
    apt_cut = 0;
    for (int i = 0; i < 1024; i++) send_bit(i % 4 == 3);
    quiet();
    wait_cyc(40);
    chk(health_err == 1'b1, "R5 default proportion cutoff fails 768", health_err, 1);
    chk(ngot == 0, "R6 no words from biased window", ngot, 0);
  endtask

  task automatic t_rct_edge();
    reset_dut();
    rct_cut = 8'd5;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_bit(1'b0);
    quiet();
    chk(health_err == 1'b0, "R3 run one below cutoff", health_err, 0);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    quiet();
    chk(health_err == 1'b1, "R3 run at cutoff", health_err, 1);
    rct_cut = 8'd0;
  endtask

  task automatic t_rct_default_and_errors();
    reset_dut();
    rct_cut = 0;
    for (int i = 0; i < 31; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 30; i++) send_bit(1'b0);
    quiet();
    chk(health_err == 1'b0, "R5 default run of 31 passes", health_err, 0);
    send_bit(1'b0);
    quiet();
    chk(health_err == 1'b1, "R5 default run of 32 fails", health_err, 1);
    irq_en = 1'b0;
    wait_cyc(1);
    chk(irq == 1'b0, "R7 irq masked", irq, 0);
    irq_en = 1'b1;
    wait_cyc(1);
    chk(irq == 1'b1, "R7 irq raised", irq, 1);
    ngot = 0;
    send_window(5, 0, 0);
    quiet();
    wait_cyc(40);
    chk(ngot == 0, "R6 bits ignored after error", ngot, 0);
    chk(health_err == 1'b1, "R6 error sticky", health_err, 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(health_err == 1'b0, "R8 clr clears error", health_err, 0);
    chk(irq == 1'b0, "R8 clr clears irq", irq, 0);
    ngot = 0;
    send_window(6, 0, 0);
    quiet();
    wait_cyc(40);
    chk(ngot == 32, "R8 fresh window after clr", ngot, 32);
    expect_window(0, 6, "R8 window data after clr");
  endtask

  initial begin
    t_reset();
    t_default_window();
    t_gaps();
    t_back2back();
    t_apt_edge();
    t_apt_default();
    t_rct_edge();
    t_rct_default_and_errors();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule